// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block holds sixteen 16-bit general registers in one physical array and lets a datapath reach that array through four overlapping views. A single access can address an 8-bit byte, a 16-bit word, a 32-bit pair or a 64-bit group of four words. Because every view maps onto the same storage, a write through one view is seen at once by every other view that covers the same bits.

Two combinational read ports and one synchronous write port are provided. Each port takes a 4-bit register index and a 2-bit size code. A dedicated stack-pointer output always presents the current stack register, and a mode input chooses which register that is: a 32-bit pair in segmented mode or a single word otherwise.

Read results are zero-extended to 64 bits. The write port takes a 64-bit value and consumes only the low bits that the selected size needs.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all sixteen words to zero.
- R2: Size code 01 selects word view: index n reads or writes all 16 bits of word n.
- R3: Size code 00 selects byte view. Index n in 0..7 maps to bits 15:8 of word n, and index n in 8..15 maps to bits 7:0 of word n-8. A byte read returns the byte in result bits 7:0.
- R4: A byte write changes only the addressed byte. The other byte of that word and all other words keep their values.
- R5: Size code 10 selects pair view with base index n with bit 0 cleared, and index bit 0 is ignored. Word n holds bits 31:16 and word n+1 holds bits 15:0. A write updates both words on the same edge.
- R6: Size code 11 selects group view with base index n with bits 1:0 cleared, and those bits are ignored. Words n, n+1, n+2 and n+3 hold bits 63:48, 47:32, 31:16 and 15:0. A write updates all four on the same edge.
- R7: Read results are zero above the selected size: above bit 7 for byte, bit 15 for word and bit 31 for pair. Write data bits above the selected size have no effect.
- R8: Both read ports are combinational and independent. During a cycle in which a write is pending, they return the value stored before that edge.
- R9: With `seg_mode` = 1, `sp_value` is {word 14, word 15}. With `seg_mode` = 0, `sp_value` is {16'h0000, word 15}.
- R10: While `wr_en` is low, no word changes, whatever the values on the other write inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_mode | input | 1 | Selects the stack register: 1 selects the pair at 14, 0 selects word 15 |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code (00 byte, 01 word, 10 pair, 11 group) |
| rd_a_data | output | 64 | Read port A result, zero-extended |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 64 | Read port B result, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 64 | Write data; only the low bits of the selected size are used |
| sp_value | output | 32 | Current stack register value |

## Verification
Read results and `sp_value` depend only on the stored words and the read inputs, so they are due in the same cycle as those inputs. A write becomes visible on every view one rising edge after `wr_en` is sampled high. The bench drives inputs at the falling edge and samples one nanosecond later. Write results are therefore checked one clock after the write was presented. The pre-write value is checked in the half cycle before that edge.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

  parameter int unsigned RF_WORDS  = 16;
  parameter int unsigned RF_WORD_W = 16;
  parameter int unsigned RF_IDX_W  = $clog2(RF_WORDS);
  parameter int unsigned RF_HALF_W = RF_WORD_W / 2;
  parameter int unsigned RF_PORT_W = 4 * RF_WORD_W;
  parameter int unsigned RF_SP_W   = 2 * RF_WORD_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } rf_size_e;

  typedef logic [RF_IDX_W-1:0] rf_idx_t;
  typedef logic [RF_WORDS-1:0][RF_WORD_W-1:0] rf_words_t;

  // number of words a view spans
  function automatic int unsigned words_of(rf_size_e s);
    case (s)
      SZ_LONG: return 2;
      SZ_QUAD: return 4;
      default: return 1;
    endcase
  endfunction

  // first word of a view: unusable low index bits are forced to zero
  function automatic rf_idx_t base_index(rf_idx_t idx, rf_size_e s);
    case (s)
      SZ_LONG: return {idx[RF_IDX_W-1:1], 1'b0};
      SZ_QUAD: return {idx[RF_IDX_W-1:2], 2'b00};
      default: return idx;
    endcase
  endfunction

  // byte view: upper half of the index space selects the low byte
  function automatic logic byte_is_high(rf_idx_t idx);
    return ~idx[RF_IDX_W-1];
  endfunction

  function automatic rf_idx_t byte_word(rf_idx_t idx);
    return {1'b0, idx[RF_IDX_W-2:0]};
  endfunction

  // word-sized slice of a wide value; slot 0 is the least significant
  function automatic logic [RF_WORD_W-1:0] word_slot(logic [RF_PORT_W-1:0] v, int unsigned slot);
    return RF_WORD_W'(v >> (RF_WORD_W * slot));
  endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import alias_rf_pkg::*;
(
  input  logic                  wr_en,
  input  rf_idx_t               wr_idx,
  input  rf_size_e              wr_size,
  input  logic [RF_PORT_W-1:0]  wr_data,
  output logic [RF_WORDS-1:0]   we_hi,
  output logic [RF_WORDS-1:0]   we_lo,
  output rf_words_t             wdata
);

  rf_idx_t     base;
  int unsigned span;

  always_comb begin
    base = base_index(wr_idx, wr_size);
    span = words_of(wr_size);
    for (int k = 0; k < int'(RF_WORDS); k++) begin
      int off;
      we_hi[k] = 1'b0;
      we_lo[k] = 1'b0;
      wdata[k] = '0;
      off = k - int'(base);
      if (wr_en) begin
        if (wr_size == SZ_BYTE) begin
          if (rf_idx_t'(k) == byte_word(wr_idx)) begin
            we_hi[k] = byte_is_high(wr_idx);
            we_lo[k] = ~byte_is_high(wr_idx);
            wdata[k] = {wr_data[RF_HALF_W-1:0], wr_data[RF_HALF_W-1:0]};
          end
        end else if (off >= 0 && off < int'(span)) begin
          we_hi[k] = 1'b1;
          we_lo[k] = 1'b1;
          wdata[k] = word_slot(wr_data, span - 1 - int'(off));
        end
      end
    end
  end

endmodule

// File: rtl/rf_store.sv
module rf_store
  import alias_rf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [RF_WORDS-1:0] we_hi,
  input  logic [RF_WORDS-1:0] we_lo,
  input  rf_words_t           wdata,
  output rf_words_t           words_q
);

  for (genvar g = 0; g < int'(RF_WORDS); g++) begin : g_word
    logic [RF_WORD_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= '0;
      end else begin
        if (we_hi[g]) cell_q[RF_WORD_W-1:RF_HALF_W] <= wdata[g][RF_WORD_W-1:RF_HALF_W];
        if (we_lo[g]) cell_q[RF_HALF_W-1:0]         <= wdata[g][RF_HALF_W-1:0];
      end
    end
    assign words_q[g] = cell_q;
  end

endmodule

// File: rtl/rf_rd_view.sv
module rf_rd_view
  import alias_rf_pkg::*;
(
  input  rf_words_t             words,
  input  rf_idx_t               idx,
  input  rf_size_e              size,
  output logic [RF_PORT_W-1:0]  data
);

  rf_idx_t     base;
  int unsigned span;
  logic [RF_WORD_W-1:0] byte_src;

  always_comb begin
    base     = base_index(idx, size);
    span     = words_of(size);
    byte_src = words[byte_word(idx)];
    data     = '0;
    if (size == SZ_BYTE) begin
      data[RF_HALF_W-1:0] = byte_is_high(idx) ? byte_src[RF_WORD_W-1:RF_HALF_W]
                                              : byte_src[RF_HALF_W-1:0];
    end else begin
      for (int j = 0; j < 4; j++) begin
        if (j < int'(span)) begin
          data = (data << RF_WORD_W) | RF_PORT_W'(words[base + rf_idx_t'(j)]);
        end
      end
    end
  end

endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 seg_mode,
  input  logic [3:0]           rd_a_idx,
  input  logic [1:0]           rd_a_size,
  output logic [63:0]          rd_a_data,
  input  logic [3:0]           rd_b_idx,
  input  logic [1:0]           rd_b_size,
  output logic [63:0]          rd_b_data,
  input  logic                 wr_en,
  input  logic [3:0]           wr_idx,
  input  logic [1:0]           wr_size,
  input  logic [63:0]          wr_data,
  output logic [31:0]          sp_value
);

  localparam int unsigned SP_PAIR_IDX = RF_WORDS - 2;
  localparam int unsigned SP_WORD_IDX = RF_WORDS - 1;

  logic [RF_WORDS-1:0] we_hi;
  logic [RF_WORDS-1:0] we_lo;
  rf_words_t           wdata;
  rf_words_t           words_q;

  rf_wr_decode u_dec (
    .wr_en   (wr_en),
    .wr_idx  (rf_idx_t'(wr_idx)),
    .wr_size (rf_size_e'(wr_size)),
    .wr_data (wr_data),
    .we_hi   (we_hi),
    .we_lo   (we_lo),
    .wdata   (wdata)
  );

  rf_store u_store (
    .clk     (clk),
    .rst     (rst),
    .we_hi   (we_hi),
    .we_lo   (we_lo),
    .wdata   (wdata),
    .words_q (words_q)
  );

  rf_rd_view u_rd_a (
    .words (words_q),
    .idx   (rf_idx_t'(rd_a_idx)),
    .size  (rf_size_e'(rd_a_size)),
    .data  (rd_a_data)
  );

  rf_rd_view u_rd_b (
    .words (words_q),
    .idx   (rf_idx_t'(rd_b_idx)),
    .size  (rf_size_e'(rd_b_size)),
    .data  (rd_b_data)
  );

  assign sp_value = seg_mode ? {words_q[SP_PAIR_IDX], words_q[SP_WORD_IDX]}
                             : {{RF_WORD_W{1'b0}}, words_q[SP_WORD_IDX]};

endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk
  import alias_rf_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [1:0]  wr_size,
  input logic [63:0] wr_data,
  input logic [1:0]  rd_b_size,
  input logic [63:0] rd_b_data,
  input logic [31:0] sp_value,
  input rf_words_t   words_q
);

  logic wr_byte, wr_word15, wr_long, wr_quad;
  assign wr_byte   = wr_en && (wr_size == SZ_BYTE);
  assign wr_word15 = wr_en && (wr_size == SZ_WORD) && (wr_idx == 4'd15);
  assign wr_long   = wr_en && (wr_size == SZ_LONG);
  assign wr_quad   = wr_en && (wr_size == SZ_QUAD);

  // R4: the byte not addressed keeps its previous value
  assert_byte_keep_R4: assert property (@(posedge clk) disable iff (rst)
    wr_byte |=> ($past(wr_idx[3])
      ? (words_q[$past(wr_idx[2:0])][15:8] == $past(words_q[wr_idx[2:0]][15:8]))
      : (words_q[$past(wr_idx[2:0])][7:0]  == $past(words_q[wr_idx[2:0]][7:0]))));

  // R5: pair write lands in the even word and its neighbour
  assert_long_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_long |=> ({words_q[{$past(wr_idx[3:1]), 1'b0}], words_q[{$past(wr_idx[3:1]), 1'b1}]}
                 == $past(wr_data[31:0])));

  // R6: group write lands in four aligned words
  assert_quad_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_quad |=> ({words_q[{$past(wr_idx[3:2]), 2'b00}], words_q[{$past(wr_idx[3:2]), 2'b01}],
                  words_q[{$past(wr_idx[3:2]), 2'b10}], words_q[{$past(wr_idx[3:2]), 2'b11}]}
                 == $past(wr_data)));

  // R7: narrow reads are zero-extended
  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_b_size == SZ_BYTE) |-> (rd_b_data[63:8] == 56'h0));

  // R9: stack register low half follows a word write to register 15
  assert_sp_follow_R9: assert property (@(posedge clk) disable iff (rst)
    wr_word15 |=> (sp_value[15:0] == $past(wr_data[15:0])));

  // R10: no write, no change
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(words_q));

endmodule

bind alias_regfile alias_regfile_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_size   (wr_size),
  .wr_data   (wr_data),
  .rd_b_size (rd_b_size),
  .rd_b_data (rd_b_data),
  .sp_value  (sp_value),
  .words_q   (words_q)
);

// File: tb/alias_regfile_bench.sv
`timescale 1ns/1ps
module alias_regfile_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_mode = 1'b0;
  logic [3:0]  rd_a_idx = '0;
  logic [1:0]  rd_a_size = '0;
  logic [63:0] rd_a_data;
  logic [3:0]  rd_b_idx = '0;
  logic [1:0]  rd_b_size = '0;
  logic [63:0] rd_b_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic [63:0] wr_data = '0;
  logic [31:0] sp_value;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] m [16];

  always #5 clk = ~clk;

  alias_regfile u_alias_regfile (
    .clk(clk), .rst(rst), .seg_mode(seg_mode),
    .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .sp_value(sp_value)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string size_tag(logic [1:0] s);
    case (s)
      2'b00: return "R3 byte";
      2'b01: return "R2 word";
      2'b10: return "R5 pair";
      default: return "R6 group";
    endcase
  endfunction

  // expected view value, written from the requirements
  function automatic logic [63:0] model_read(logic [3:0] idx, logic [1:0] s);
    logic [63:0] r = '0;
    case (s)
      2'b00: r = (idx < 4'd8) ? {56'h0, m[idx][15:8]} : {56'h0, m[idx - 4'd8][7:0]};
      2'b01: r = {48'h0, m[idx]};
      2'b10: r = {32'h0, m[{idx[3:1], 1'b0}], m[{idx[3:1], 1'b1}]};
      default: for (int k = 0; k < 4; k++) r = r * 64'h10000 + 64'(m[{idx[3:2], 2'(k)}]);
    endcase
    return r;
  endfunction

  task automatic model_write(logic [3:0] idx, logic [1:0] s, logic [63:0] d);
    case (s)
      2'b00: if (idx < 4'd8) m[idx][15:8] = d[7:0]; else m[idx - 4'd8][7:0] = d[7:0];
      2'b01: m[idx] = d[15:0];
      2'b10: begin m[{idx[3:1], 1'b0}] = d[31:16]; m[{idx[3:1], 1'b1}] = d[15:0]; end
      default: for (int k = 0; k < 4; k++) m[{idx[3:2], 2'(k)}] = d[63 - 16*k -: 16];
    endcase
  endtask

  task automatic do_write(logic [3:0] idx, logic [1:0] s, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_size = s; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model_write(idx, s, d);
  endtask

  task automatic read_a(logic [3:0] idx, logic [1:0] s, string tag);
    @(negedge clk);
    rd_a_idx = idx; rd_a_size = s;
    #1;
    chk(tag, rd_a_data, model_read(idx, s));
  endtask

  task automatic sweep_all(string tag);
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        rd_a_idx = 4'(i); rd_a_size = 2'(s);
        rd_b_idx = 4'(15 - i); rd_b_size = 2'(3 - s);
        #1;
        chk({tag, " A ", size_tag(2'(s))}, rd_a_data, model_read(4'(i), 2'(s)));
        chk({tag, " B ", size_tag(2'(3 - s)), " R8 R7"}, rd_b_data, model_read(4'(15 - i), 2'(3 - s)));
      end
    end
  endtask

  task automatic check_sp(string tag);
    @(negedge clk);
    seg_mode = 1'b0; #1;
    chk({tag, " R9 word"}, {32'h0, sp_value}, {48'h0, m[15]});
    seg_mode = 1'b1; #1;
    chk({tag, " R9 pair"}, {32'h0, sp_value}, {32'h0, m[14], m[15]});
  endtask

  initial begin
    for (int k = 0; k < 16; k++) m[k] = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: all words zero after reset
    for (int i = 0; i < 16; i++) read_a(4'(i), 2'b01, "R1 reset word");
    check_sp("R1 reset");

    // R2: word writes to every register
    for (int i = 0; i < 16; i++) begin
      do_write(4'(i), 2'b01, {48'hFFFF_FFFF_FFFF, 16'(i * 16'h1357) ^ 16'hC3A5});
      read_a(4'(i), 2'b01, "R2 word write R7");
    end
    sweep_all("after words");
    check_sp("after words");

    // R3 R4 R7: byte writes at all indices, upper data bits are junk
    for (int i = 0; i < 16; i++) begin
      do_write(4'(i), 2'b00, {56'hAAAA_AAAA_AAAA_AA, 8'(i * 37 + 5)});
      read_a(4'(i & 7), 2'b01, "R4 byte write keeps other byte");
      read_a(4'(i), 2'b00, "R3 byte readback");
    end
    sweep_all("after bytes");

    // R5: pair writes, odd indices alias the even base
    for (int i = 0; i < 16; i++) begin
      do_write(4'(i), 2'b10, {32'h5555_5555, 16'(i * 16'h0F1D + 16'h2468), 16'(i * 16'h3C07 + 16'h9)});
      read_a(4'(i ^ 1), 2'b10, "R5 pair alias");
      read_a(4'(i), 2'b11, "R5 R6 pair in group");
    end
    sweep_all("after pairs");

    // R6: group writes, low two index bits ignored
    for (int i = 0; i < 16; i++) begin
      do_write(4'(i), 2'b11, {16'(i * 16'h1111), 16'(i + 16'h8001), 16'(~(i * 16'h0707)), 16'(i * 16'h00F3 + 16'h4000)});
      read_a(4'(i ^ 3), 2'b11, "R6 group alias");
    end
    sweep_all("after groups");
    check_sp("after groups");

    // R8: read during the cycle of a write shows the old value
    @(negedge clk);
    rd_a_idx = 4'd3; rd_a_size = 2'b01;
    wr_en = 1'b1; wr_idx = 4'd3; wr_size = 2'b01; wr_data = 64'h0000_0000_0000_BEEF;
    #1;
    chk("R8 pre-edge old value", rd_a_data, {48'h0, m[3]});
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model_write(4'd3, 2'b01, 64'hBEEF);
    chk("R8 post-edge new value", rd_a_data, 64'hBEEF);

    // R9: stack register after word write to 15 in both modes
    do_write(4'd15, 2'b01, 64'h7A5C);
    check_sp("R9 after R15 write");
    do_write(4'd14, 2'b01, 64'h1234);
    check_sp("R9 after R14 write");

    // R10: write inputs toggle with enable low
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_idx = 4'(i * 3); wr_size = 2'(i); wr_data = {4{16'(i * 16'h2F1)}};
    end
    sweep_all("R10 hold");

    // R1: reset again after data present
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 16; k++) m[k] = 16'h0;
    sweep_all("R1 second reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule